// File: doc/BRIEF.md
# Register Write-Pending Scoreboard

This block tracks, for every architectural register, whether a result is still owed to it by an instruction already handed to a function unit. An in-order issue stage uses it to hold back an instruction whose source registers are not yet final (a read-after-write hazard), while several function units share a single register file.

A pending bit is raised in the cycle an instruction that writes a register is issued. It is dropped either when that unit is granted the register-file write port, or when the unit reports completion without a valid result. The second case cannot happen on units listed in an exemption mask; these are units assumed always to deliver what they declared. Each unit remembers its destination and its write intent from issue time. The check side takes up to a fixed number of source-register selects. It raises a combinational hazard flag when any enabled source still has its bit set. Once the consuming unit is busy and a source was seen clear, that source stops probing. Register selects are either binary register numbers or one-hot vectors, chosen by a parameter.

Top module: `wpend_scoreboard`

## Requirements
- R1: After reset every pending bit is 0 and the hazard output is 0.
- R2: When unit u has iss_go[u]=1, iss_wr[u]=1 and raw_hazard=0, the bit of its destination register reads 1 from the next clock edge onward.
- R3: An issue with iss_wr[u]=0 raises no pending bit.
- R4: When wb_grant[u]=1, the bit of the destination that unit u latched at its last accepted issue reads 0 after the next edge.
- R5: When unit u is not exempt, unit_done[u]=1, unit_res_ok[u]=0 and its write intent latched at issue is 1, the bit of its latched destination reads 0 after the next edge.
- R6: A unit's latched write intent is cleared on any edge where unit_busy[u]=0 and no issue is accepted for it; a later completion without result then clears nothing.
- R7: For units whose bit in the exemption mask is 1 (default: unit 3 only), completion without a valid result clears nothing.
- R8: raw_hazard is 1 in the same cycle when some source k has chk_en[k]=1, has not stopped probing, and the bit of register chk_sel[k] is 1; it is 0 otherwise.
- R9: A source k stops probing after an edge where chk_busy=1, chk_en[k]=1 and its bit was 0; it resumes after an edge where chk_busy=0.
- R10: When a bit is both set and cleared in one cycle, the clear wins and the bit reads 0.
- R11: An issue presented while raw_hazard=1 is not accepted: it sets no bit and does not update the unit's latched destination or write intent.
- R12: In binary mode a select value n addresses bit n; in one-hot mode the select vector addresses its set bits directly; both modes give identical results for equivalent selects.
- R13: Set and clear requests from all units in one cycle are combined; each requested bit is updated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_go | input | NUNITS | Issue strobe per unit |
| iss_wr | input | NUNITS | Issued instruction writes a register, per unit |
| iss_dst | input | NUNITS*SELW | Destination register select per unit |
| unit_busy | input | NUNITS | Unit is executing |
| unit_done | input | NUNITS | Unit finished its operation this cycle |
| unit_res_ok | input | NUNITS | Unit's result is valid and will be written |
| wb_grant | input | NUNITS | Register-file write port granted to the unit |
| chk_en | input | NSRC | Source operand k wants to read a register |
| chk_sel | input | NSRC*SELW | Source register select per operand |
| chk_busy | input | 1 | Consuming unit of the checked instruction is busy |
| raw_hazard | output | 1 | A read-after-write hazard is present |
| pend_o | output | NREGS | Current pending-write bits |

## Verification
Every cycle the assertions check that cleared bits read low after the edge (so clears beat sets), that surviving set requests read high, that no bit moves without a request, that no set is made while a hazard is flagged and that an empty scoreboard never flags a hazard. Which register a grant or a silent completion releases, the intent latch being dropped while a unit is idle, the exemption of units, the probe stop of a busy consumer and the equivalence of binary and one-hot selects depend on histories of several cycles. Only the bench scenarios, run against a reference model on both addressing variants, show these.

// File: rtl/sb_pkg.sv
// Shared types and helpers for the write-pending scoreboard.
// Assumes: register count is at least 2.
package sb_pkg;

    typedef enum logic {
        SEL_BINARY = 1'b0,
        SEL_ONEHOT = 1'b1
    } sel_mode_e;

    // Width of one register select for the chosen addressing mode
    function automatic int sel_width(sel_mode_e mode, int nregs);
        if (mode == SEL_ONEHOT) return nregs;
        return (nregs > 1) ? $clog2(nregs) : 1;
    endfunction

endpackage

// File: rtl/sb_sel_decode.sv
// Turns one register select into a per-register enable vector.
// Binary mode: a one shifted left by the register number.
// One-hot mode: the select is used as the enable directly.
// Assumes: binary values at or above NREGS produce an all-zero vector.
module sb_sel_decode
    import sb_pkg::*;
#(
    parameter int        NREGS    = 32,
    parameter sel_mode_e SEL_MODE = SEL_BINARY,
    parameter int        SELW     = 5
) (
    input  logic [SELW-1:0]  sel_i,
    input  logic             en_i,
    output logic [NREGS-1:0] vec_o
);

    generate
        if (SEL_MODE == SEL_ONEHOT) begin : g_onehot
            // One-hot select passes straight through, gated by enable
            always_comb begin
                vec_o = '0;
                for (int i = 0; i < NREGS; i++) begin
                    if (i < SELW) vec_o[i] = en_i & sel_i[i];
                end
            end
        end else begin : g_binary
            localparam logic [NREGS-1:0] ONE = NREGS'(1);
            // Binary select becomes a shifted single bit, gated by enable
            always_comb begin
                vec_o = en_i ? (ONE << sel_i) : '0;
            end
        end
    endgenerate

endmodule

// File: rtl/sb_bits.sv
// Storage of the pending-write bits. Clear has priority over set.
// Assumes: set and clear vectors are already OR-combined across units.
module sb_bits #(
    parameter int NREGS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREGS-1:0] set_i,
    input  logic [NREGS-1:0] clr_i,
    output logic [NREGS-1:0] q_o
);

    // Update the bit vector: raise on set, lower on clear, clear wins
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= (q_o | set_i) & ~clr_i;
    end

endmodule

// File: rtl/sb_unit_track.sv
// Per-function-unit bookkeeping for the scoreboard.
// Latches destination and write intent at an accepted issue, produces the
// set vector at issue and the clear vector at write-back grant or at a
// completion that carries no valid result.
// Assumes: issue_ok is already qualified by the absence of a hazard.
module sb_unit_track
    import sb_pkg::*;
#(
    parameter int        NREGS    = 32,
    parameter sel_mode_e SEL_MODE = SEL_BINARY,
    parameter int        SELW     = 5,
    parameter bit        NOWR_CLR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_ok_i,
    input  logic             wr_flag_i,
    input  logic [SELW-1:0]  dst_sel_i,
    input  logic             busy_i,
    input  logic             done_i,
    input  logic             res_ok_i,
    input  logic             grant_i,
    output logic [NREGS-1:0] set_o,
    output logic [NREGS-1:0] clr_o
);

    logic [NREGS-1:0] dst_now;
    logic [NREGS-1:0] dst_q;
    logic             wr_lat_q;
    logic             silent_done;

    sb_sel_decode #(
        .NREGS   (NREGS),
        .SEL_MODE(SEL_MODE),
        .SELW    (SELW)
    ) dst_dec_i (
        .sel_i(dst_sel_i),
        .en_i (1'b1),
        .vec_o(dst_now)
    );

    // Capture destination register at every accepted issue
    always_ff @(posedge clk) begin
        if (!rst_n)          dst_q <= '0;
        else if (issue_ok_i) dst_q <= dst_now;
    end

    // Write-intent latch: loaded at issue, dropped while the unit is idle
    always_ff @(posedge clk) begin
        if (!rst_n)          wr_lat_q <= 1'b0;
        else if (issue_ok_i) wr_lat_q <= wr_flag_i;
        else if (!busy_i)    wr_lat_q <= 1'b0;
    end

    // Completion that promised a write but will never deliver one
    always_comb begin
        silent_done = NOWR_CLR & done_i & wr_lat_q & ~res_ok_i;
    end

    // Set request at issue when the instruction writes a register
    always_comb begin
        set_o = (issue_ok_i & wr_flag_i) ? dst_now : '0;
    end

    // Clear request at write-back grant or silent completion
    always_comb begin
        clr_o = (grant_i | silent_done) ? dst_q : '0;
    end

endmodule

// File: rtl/sb_probe.sv
// One source-operand check of the scoreboard.
// Reports a hit when the selected register has a write outstanding, and
// stops probing once the consumer is busy and the operand was seen clear.
// Assumes: chk_busy stays high for the whole time the consumer executes.
module sb_probe
    import sb_pkg::*;
#(
    parameter int        NREGS    = 32,
    parameter sel_mode_e SEL_MODE = SEL_BINARY,
    parameter int        SELW     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [SELW-1:0]  sel_i,
    input  logic             busy_i,
    input  logic [NREGS-1:0] pend_i,
    output logic             hit_o
);

    logic [NREGS-1:0] sel_vec;
    logic             raw_hit;
    logic             stop_q;

    sb_sel_decode #(
        .NREGS   (NREGS),
        .SEL_MODE(SEL_MODE),
        .SELW    (SELW)
    ) src_dec_i (
        .sel_i(sel_i),
        .en_i (en_i),
        .vec_o(sel_vec)
    );

    // Masked pending bits of this operand, before the stop gate
    always_comb begin
        raw_hit = |(pend_i & sel_vec);
    end

    // Stop flag: set when busy and found clear, released when not busy
    always_ff @(posedge clk) begin
        if (!rst_n)       stop_q <= 1'b0;
        else if (!busy_i) stop_q <= 1'b0;
        else if (en_i && !raw_hit) stop_q <= 1'b1;
    end

    // Hazard from this operand only while it is still probing
    always_comb begin
        hit_o = raw_hit & ~stop_q;
    end

endmodule

// File: rtl/wpend_scoreboard.sv
// Top of the register write-pending scoreboard.
// Holds one pending bit per register, fed by per-unit trackers and read by
// per-operand probes. Set and clear requests of all units are OR-combined.
// Assumes: one instruction is checked per cycle; issue strobes of units are
// qualified here by the hazard output so a blocked issue has no effect.
module wpend_scoreboard
    import sb_pkg::*;
#(
    parameter int              NREGS      = 32,
    parameter int              NUNITS     = 4,
    parameter int              NSRC       = 3,
    parameter sel_mode_e       SEL_MODE   = SEL_BINARY,
    parameter logic [NUNITS-1:0] EXEMPT_MASK = 4'b1000,
    localparam int             SELW       = sel_width(SEL_MODE, NREGS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUNITS-1:0]      iss_go,
    input  logic [NUNITS-1:0]      iss_wr,
    input  logic [NUNITS*SELW-1:0] iss_dst,
    input  logic [NUNITS-1:0]      unit_busy,
    input  logic [NUNITS-1:0]      unit_done,
    input  logic [NUNITS-1:0]      unit_res_ok,
    input  logic [NUNITS-1:0]      wb_grant,
    input  logic [NSRC-1:0]        chk_en,
    input  logic [NSRC*SELW-1:0]   chk_sel,
    input  logic                   chk_busy,
    output logic                   raw_hazard,
    output logic [NREGS-1:0]       pend_o
);

    logic [NREGS-1:0] unit_set [NUNITS];
    logic [NREGS-1:0] unit_clr [NUNITS];
    logic [NSRC-1:0]  src_hit;
    logic [NREGS-1:0] set_all;
    logic [NREGS-1:0] clr_all;
    logic [NUNITS-1:0] issue_ok;

    // Accept an issue only when no source operand is hazarded
    always_comb begin
        issue_ok = iss_go & {NUNITS{~raw_hazard}};
    end

    generate
        for (genvar u = 0; u < NUNITS; u++) begin : g_unit
            sb_unit_track #(
                .NREGS   (NREGS),
                .SEL_MODE(SEL_MODE),
                .SELW    (SELW),
                .NOWR_CLR(!EXEMPT_MASK[u])
            ) trk_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .issue_ok_i(issue_ok[u]),
                .wr_flag_i (iss_wr[u]),
                .dst_sel_i (iss_dst[u*SELW +: SELW]),
                .busy_i    (unit_busy[u]),
                .done_i    (unit_done[u]),
                .res_ok_i  (unit_res_ok[u]),
                .grant_i   (wb_grant[u]),
                .set_o     (unit_set[u]),
                .clr_o     (unit_clr[u])
            );
        end

        for (genvar k = 0; k < NSRC; k++) begin : g_src
            sb_probe #(
                .NREGS   (NREGS),
                .SEL_MODE(SEL_MODE),
                .SELW    (SELW)
            ) prb_i (
                .clk   (clk),
                .rst_n (rst_n),
                .en_i  (chk_en[k]),
                .sel_i (chk_sel[k*SELW +: SELW]),
                .busy_i(chk_busy),
                .pend_i(pend_o),
                .hit_o (src_hit[k])
            );
        end
    endgenerate

    // OR-combine the set and clear requests of all units
    always_comb begin
        set_all = '0;
        clr_all = '0;
        for (int u = 0; u < NUNITS; u++) begin
            set_all = set_all | unit_set[u];
            clr_all = clr_all | unit_clr[u];
        end
    end

    // Hazard is the OR of all still-probing operand hits
    always_comb begin
        raw_hazard = |src_hit;
    end

    sb_bits #(
        .NREGS(NREGS)
    ) bits_i (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(set_all),
        .clr_i(clr_all),
        .q_o  (pend_o)
    );

endmodule

// File: rtl/wpend_scoreboard_chk.sv
// Checker for the write-pending scoreboard, bound into the top module.
// Relates the combined set/clear requests to the stored bits and hazard.
module wpend_scoreboard_chk #(
    parameter int NREGS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NREGS-1:0] pend_o,
    input logic [NREGS-1:0] set_all,
    input logic [NREGS-1:0] clr_all,
    input logic             raw_hazard
);

    // R4, R10: every cleared bit reads low after the edge, even if also set
    a_r4_cleared_low: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all != '0) |=> ((pend_o & $past(clr_all)) == '0));

    // R2, R13: every set bit not also cleared reads high after the edge
    a_r2_set_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_all & ~clr_all) != '0) |=>
        ((pend_o & $past(set_all & ~clr_all)) == $past(set_all & ~clr_all)));

    // R13: with no requests, the bits hold
    a_r13_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (set_all == '0 && clr_all == '0) |=> $stable(pend_o));

    // R11: no set request while a hazard is flagged
    a_r11_no_set_on_hazard: assert property (@(posedge clk) disable iff (!rst_n)
        raw_hazard |-> (set_all == '0));

    // R8: an empty scoreboard cannot flag a hazard
    a_r8_empty_no_hazard: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o == '0) |-> !raw_hazard);

endmodule

bind wpend_scoreboard wpend_scoreboard_chk #(
    .NREGS(NREGS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_o    (pend_o),
    .set_all   (set_all),
    .clr_all   (clr_all),
    .raw_hazard(raw_hazard)
);

// File: tb/wpend_scoreboard_tb_top.sv
// Bench: drives a binary-select and a one-hot-select instance with the same
// stimulus and compares both against a reference model built from the
// requirements.
module wpend_scoreboard_tb_top;
    import sb_pkg::*;

    localparam int NR  = 32;
    localparam int NU  = 4;
    localparam int NS  = 3;
    localparam int SB  = 5;
    localparam logic [NU-1:0] EXEMPT = 4'b1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [NU-1:0] go, wr, busy, done, rok, grant;
    int unsigned   dst [NU];
    logic [NS-1:0] cen;
    int unsigned   csel [NS];
    logic          cbusy;

    logic [NU*SB-1:0] dst_b;
    logic [NU*NR-1:0] dst_o;
    logic [NS*SB-1:0] csel_b;
    logic [NS*NR-1:0] csel_o;

    always_comb begin
        for (int u = 0; u < NU; u++) begin
            dst_b[u*SB +: SB] = dst[u][SB-1:0];
            dst_o[u*NR +: NR] = 32'(1) << dst[u];
        end
        for (int k = 0; k < NS; k++) begin
            csel_b[k*SB +: SB] = csel[k][SB-1:0];
            csel_o[k*NR +: NR] = 32'(1) << csel[k];
        end
    end

    logic          haz_b, haz_o;
    logic [NR-1:0] pend_b, pend_oh;

    wpend_scoreboard #(.NREGS(NR), .NUNITS(NU), .NSRC(NS),
        .SEL_MODE(SEL_BINARY), .EXEMPT_MASK(EXEMPT)) dut_i (
        .clk(clk), .rst_n(rst_n), .iss_go(go), .iss_wr(wr), .iss_dst(dst_b),
        .unit_busy(busy), .unit_done(done), .unit_res_ok(rok),
        .wb_grant(grant), .chk_en(cen), .chk_sel(csel_b), .chk_busy(cbusy),
        .raw_hazard(haz_b), .pend_o(pend_b));

    wpend_scoreboard #(.NREGS(NR), .NUNITS(NU), .NSRC(NS),
        .SEL_MODE(SEL_ONEHOT), .EXEMPT_MASK(EXEMPT)) dut_oh_i (
        .clk(clk), .rst_n(rst_n), .iss_go(go), .iss_wr(wr), .iss_dst(dst_o),
        .unit_busy(busy), .unit_done(done), .unit_res_ok(rok),
        .wb_grant(grant), .chk_en(cen), .chk_sel(csel_o), .chk_busy(cbusy),
        .raw_hazard(haz_o), .pend_o(pend_oh));

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [NR-1:0] m_pend;
    logic [NR-1:0] m_dst [NU];
    logic [NU-1:0] m_wlat;
    logic [NS-1:0] m_stop;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic f_hazard();
        logic h = 1'b0;
        for (int k = 0; k < NS; k++)
            if (cen[k] && !m_stop[k] && m_pend[csel[k]]) h = 1'b1;
        return h;
    endfunction

    task automatic model_advance();
        logic          h = f_hazard();
        logic [NR-1:0] s = '0;
        logic [NR-1:0] c = '0;
        for (int u = 0; u < NU; u++) begin
            logic ok = go[u] && !h;
            if (ok && wr[u]) s[dst[u]] = 1'b1;
            if (grant[u]) c = c | m_dst[u];
            if (!EXEMPT[u] && done[u] && m_wlat[u] && !rok[u]) c = c | m_dst[u];
        end
        for (int k = 0; k < NS; k++) begin
            if (!cbusy) m_stop[k] = 1'b0;
            else if (cen[k] && !m_pend[csel[k]]) m_stop[k] = 1'b1;
        end
        for (int u = 0; u < NU; u++) begin
            if (go[u] && !h) begin
                m_dst[u]  = 32'(1) << dst[u];
                m_wlat[u] = wr[u];
            end else if (!busy[u]) begin
                m_wlat[u] = 1'b0;
            end
        end
        m_pend = (m_pend | s) & ~c;
    endtask

    task automatic idle();
        go = '0; wr = '0; busy = '0; done = '0; rok = '0; grant = '0;
        cen = '0; cbusy = 1'b0;
        for (int u = 0; u < NU; u++) dst[u] = 0;
        for (int k = 0; k < NS; k++) csel[k] = 0;
    endtask

    // Inputs are already driven after a negedge; check hazard, clock, check bits
    task automatic step(string tag);
        #1;
        check({tag, " hazard bin"}, 32'(haz_b), 32'(f_hazard()));
        check({tag, " hazard onehot"}, 32'(haz_o), 32'(f_hazard()));
        model_advance();
        @(posedge clk); #1;
        check({tag, " pend bin"}, pend_b, m_pend);
        check({tag, " pend onehot"}, pend_oh, m_pend);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED_0042);
        idle();
        m_pend = '0; m_wlat = '0; m_stop = '0;
        for (int u = 0; u < NU; u++) m_dst[u] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 pend", pend_b, 32'h0);
        check("R1 pend onehot", pend_oh, 32'h0);
        check("R1 hazard", 32'(haz_b), 32'h0);

        // R2: issue with write raises bit 5
        idle(); go[0] = 1; wr[0] = 1; dst[0] = 5; step("R2");
        // R3: issue without write raises nothing
        idle(); busy[0] = 1; go[1] = 1; wr[1] = 0; dst[1] = 7; step("R3");
        // R4: grant clears latched destination 5
        idle(); busy[0] = 1; grant[0] = 1; step("R4");
        // R5: silent completion clears bit 9
        idle(); go[1] = 1; wr[1] = 1; dst[1] = 9; step("R5");
        idle(); busy[1] = 1; done[1] = 1; rok[1] = 0; step("R5");
        // R6: intent latch dropped while idle, completion then clears nothing
        idle(); go[2] = 1; wr[2] = 1; dst[2] = 11; step("R6");
        idle(); step("R6");
        idle(); busy[2] = 1; done[2] = 1; step("R6");
        // R7: exempt unit 3 completion without result keeps bit 12
        idle(); go[3] = 1; wr[3] = 1; dst[3] = 12; step("R7");
        idle(); busy[3] = 1; done[3] = 1; step("R7");
        // R8: hazard on a pending source, none on a clear one
        idle(); cen[0] = 1; csel[0] = 12; step("R8");
        idle(); cen[1] = 1; csel[1] = 13; step("R8");
        // R11: blocked issue sets nothing
        idle(); cen[2] = 1; csel[2] = 12; go[0] = 1; wr[0] = 1; dst[0] = 20; step("R11");
        // R10: clear beats set on the same bit
        idle(); go[0] = 1; wr[0] = 1; dst[0] = 4; step("R10");
        idle(); busy[0] = 1; grant[0] = 1; go[1] = 1; wr[1] = 1; dst[1] = 4; step("R10");
        // R9: busy consumer stops probing once it saw the source clear
        idle(); cbusy = 1; cen[0] = 1; csel[0] = 14; step("R9");
        go[0] = 1; wr[0] = 1; dst[0] = 14; step("R9");
        go[0] = 0; step("R9");
        cbusy = 0; step("R9");
        step("R9");
        // R13: two units set in one cycle
        idle(); go[0] = 1; wr[0] = 1; dst[0] = 21; go[1] = 1; wr[1] = 1; dst[1] = 22; step("R13");

        // R12: random traffic on both addressing variants
        for (int n = 0; n < 3000; n++) begin
            for (int u = 0; u < NU; u++) begin
                go[u]    = ($urandom % 100) < 30;
                wr[u]    = ($urandom % 100) < 75;
                dst[u]   = $urandom % NR;
                busy[u]  = ($urandom % 100) < 60;
                done[u]  = ($urandom % 100) < 20;
                rok[u]   = ($urandom % 100) < 50;
                grant[u] = ($urandom % 100) < 20;
            end
            for (int k = 0; k < NS; k++) begin
                cen[k]  = ($urandom % 100) < 40;
                csel[k] = $urandom % NR;
            end
            cbusy = ($urandom % 100) < 40;
            step("R12");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule